// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns up to four serial audio data lines into parallel stereo samples. Each line carries one left/right pair per frame. A single bit clock and a frame clock are shared by all lines. The bit clock runs at 64 times the frame rate, so each channel gets a slot of 32 bit periods. The block runs directly on the bit clock and samples the data lines and the frame clock on its rising edge.

Two static inputs set the framing and the word length. The framing can be I2S, left-justified or right-justified. The word length can be 16, 20 or 24 bits. Every captured word is presented as a 24-bit sample with the MSB at bit 23. Shorter words are padded with zeros in the low bits.

After the last bit of the right word in a frame, both channels of all lines update together and a one-cycle valid strobe is raised. The receiver locks on the first frame-clock transition after reset. It emits nothing until it has captured a full left word following that lock.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is held and on the first cycle after it, `valid_o` is low and every sample output is zero.
- R2: With `fmt` = 00 (I2S), a low `lrck` marks the left channel. The MSB is on the second rising edge after `lrck` changes level, followed by the remaining bits MSB first.
- R3: With `fmt` = 01 (left-justified), a high `lrck` marks the left channel. The MSB is on the first rising edge at which the new `lrck` level is seen.
- R4: With `fmt` = 10 (right-justified), a high `lrck` marks the left channel. The LSB is on the last rising edge before `lrck` changes, so capture starts at slot 32 minus the word length.
- R5: `wlen` = 00, 01 and 10 select 16, 20 and 24-bit words. A word of W bits appears in bits 23 down to 24-W of the output, and the lower 24-W bits are zero.
- R6: The four data lines are decoded in parallel. Line n drives bits 24n+23 down to 24n of `left_o` and `right_o`.
- R7: `valid_o` is high for exactly one cycle per frame, one cycle after the rising edge that samples the last bit of the right word. The sample outputs change only in that cycle and hold their values otherwise.
- R8: Data-line values in slots outside the selected word have no effect on the outputs.
- R9: No valid strobe is produced until an `lrck` transition has been seen after reset and a complete left word has followed it.
- R10: The reserved codes `fmt` = 11 and `wlen` = 11 behave as I2S and as 24 bits respectively.
- R11: Once locked, every `lrck` transition falls after exactly 32 bit periods of the previous level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; all sampling on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lrck | input | 1 | Frame (left/right) clock |
| sdata | input | 4 | Serial data, one bit per line |
| fmt | input | 2 | Framing: 00 I2S, 01 left-justified, 10 right-justified, 11 as 00 |
| wlen | input | 2 | Word length: 00 16, 01 20, 10 24, 11 as 10 |
| left_o | output | 96 | Left samples, 24 bits per line, line 0 lowest |
| right_o | output | 96 | Right samples, 24 bits per line, line 0 lowest |
| valid_o | output | 1 | One-cycle strobe when a new frame is presented |

## Verification
A slot counter that is off by one shows up in the first committed frame. Every sample then comes out shifted by one bit, or has a junk bit from a neighbouring slot in it, so one frame after lock the outputs are wrong.

If the channel select is inverted, left and right swap on every strobe. If the left-seen state is lost, frames are dropped, and the strobe count at the end of each configuration run is lower than the number of frames sent.

Wrong padding leaves non-zero low bits when the word is 16 or 20 bits long. This is visible on the very first valid strobe.

// File: rtl/audrx_pkg.sv
// Shared encodings for the serial audio receiver.
// Assumes the framing and word-length codes are static while out of reset.
package audrx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_RJ  = 2'b10,
        FMT_RSV = 2'b11
    } fmt_e;

    // Map the word-length code to a bit count; the reserved code acts as 24.
    function automatic int word_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 16;
            2'b01:   return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/audrx_framer.sv
// Frame tracker for the serial audio receiver.
// It follows the frame clock, numbers the 32 slots of each channel and
// tells the lanes when to shift, when to store a left word and when to
// present a frame.
// Assumes one bit per rising edge of clk and a well-formed 64-slot frame
// once locked.
module audrx_framer
    import audrx_pkg::*;
#(
    parameter int SLOT_LEN = 32,
    parameter int SAMPLE_W = 24,
    localparam int CNT_W   = $clog2(SLOT_LEN),
    localparam int PAD_W   = $clog2(SAMPLE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrck,
    input  logic [1:0]       fmt,
    input  logic [1:0]       wlen,
    output logic             shift_o,
    output logic             store_left_o,
    output logic             commit_o,
    output logic [PAD_W-1:0] pad_o,
    output logic             valid_o
);

    logic             primed_q;
    logic             locked_q;
    logic             lr_q;
    logic             left_seen_q;
    logic             valid_q;
    logic [CNT_W-1:0] cnt_q;

    logic             lr_edge;
    logic             locked_now;
    logic [CNT_W-1:0] slot;
    logic             left_now;
    logic             in_word;
    logic             last_bit;
    int               wb;
    int               start;
    int               slot_i;

    // Work out the current slot and whether it falls inside the word.
    always_comb begin
        lr_edge    = primed_q && (lrck != lr_q);
        locked_now = locked_q || lr_edge;
        slot       = lr_edge ? '0 : cnt_q + 1'b1;
        slot_i     = int'(slot);
        wb         = word_bits(wlen);
        case (fmt)
            FMT_LJ:  start = 0;
            FMT_RJ:  start = SLOT_LEN - wb;
            default: start = 1;
        endcase
        left_now = ((fmt == FMT_LJ) || (fmt == FMT_RJ)) ? lrck : ~lrck;
        in_word  = locked_now && (slot_i >= start) && (slot_i < start + wb);
        last_bit = in_word && (slot_i == start + wb - 1);
    end

    assign shift_o      = in_word;
    assign store_left_o = last_bit && left_now;
    assign commit_o     = last_bit && !left_now && left_seen_q;
    assign pad_o        = PAD_W'(SAMPLE_W - wb);
    assign valid_o      = valid_q;

    // Track the frame-clock level, the slot count, lock and left-word state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            primed_q    <= 1'b0;
            locked_q    <= 1'b0;
            lr_q        <= 1'b0;
            left_seen_q <= 1'b0;
            valid_q     <= 1'b0;
            cnt_q       <= '0;
        end else begin
            primed_q <= 1'b1;
            lr_q     <= lrck;
            cnt_q    <= slot;
            valid_q  <= commit_o;
            if (lr_edge)
                locked_q <= 1'b1;
            if (store_left_o)
                left_seen_q <= 1'b1;
            else if (commit_o)
                left_seen_q <= 1'b0;
        end
    end

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R9
    valid_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> locked_q);

    // R11
    slot_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && lr_edge) |-> (cnt_q == CNT_W'(SLOT_LEN - 1)));

endmodule

// File: rtl/audrx_lane.sv
// Deserializer for one data line.
// It shifts in word bits MSB first, left-aligns the finished word, keeps
// the left word until the right word is done, then updates both outputs.
// Assumes the framer gives at most SAMPLE_W shift cycles per word.
module audrx_lane #(
    parameter int SAMPLE_W = 24,
    localparam int PAD_W   = $clog2(SAMPLE_W + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sd,
    input  logic                shift_i,
    input  logic                store_left_i,
    input  logic                commit_i,
    input  logic [PAD_W-1:0]    pad_i,
    input  logic                valid_i,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o
);

    logic [SAMPLE_W-1:0] sh_q;
    logic [SAMPLE_W-1:0] hold_q;
    logic [SAMPLE_W-1:0] out_l_q;
    logic [SAMPLE_W-1:0] out_r_q;
    logic [SAMPLE_W-1:0] sh_next;
    logic [SAMPLE_W-1:0] aligned;

    // Form the next shift value and its left-aligned view.
    always_comb begin
        sh_next = {sh_q[SAMPLE_W-2:0], sd};
        aligned = sh_next << pad_i;
    end

    // Shift word bits, keep the left word, update outputs on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            hold_q  <= '0;
            out_l_q <= '0;
            out_r_q <= '0;
        end else begin
            if (shift_i)
                sh_q <= sh_next;
            if (store_left_i)
                hold_q <= aligned;
            if (commit_i) begin
                out_l_q <= hold_q;
                out_r_q <= aligned;
            end
        end
    end

    assign left_o  = out_l_q;
    assign right_o = out_r_q;

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |-> ($stable(out_l_q) && $stable(out_r_q)));

    // R5
    pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |-> (((out_l_q << (SAMPLE_W - int'(pad_i))) == '0) &&
                     ((out_r_q << (SAMPLE_W - int'(pad_i))) == '0)));

endmodule

// File: rtl/serial_audio_rx.sv
// Top level of the multi-format serial audio receiver.
// One framer drives LANES deserializers in lockstep.
// Assumes clk is the bit clock at 64 periods per frame.
module serial_audio_rx
    import audrx_pkg::*;
#(
    parameter int LANES    = 4,
    parameter int SAMPLE_W = 24,
    parameter int SLOT_LEN = 32,
    localparam int BUS_W   = LANES * SAMPLE_W,
    localparam int PAD_W   = $clog2(SAMPLE_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrck,
    input  logic [LANES-1:0] sdata,
    input  logic [1:0]       fmt,
    input  logic [1:0]       wlen,
    output logic [BUS_W-1:0] left_o,
    output logic [BUS_W-1:0] right_o,
    output logic             valid_o
);

    logic             shift;
    logic             store_left;
    logic             commit;
    logic [PAD_W-1:0] pad;

    audrx_framer #(
        .SLOT_LEN (SLOT_LEN),
        .SAMPLE_W (SAMPLE_W)
    ) u_framer (
        .clk          (clk),
        .rst_n        (rst_n),
        .lrck         (lrck),
        .fmt          (fmt),
        .wlen         (wlen),
        .shift_o      (shift),
        .store_left_o (store_left),
        .commit_o     (commit),
        .pad_o        (pad),
        .valid_o      (valid_o)
    );

    // One deserializer per data line, all sharing the framer controls.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        audrx_lane #(
            .SAMPLE_W (SAMPLE_W)
        ) u_lane (
            .clk          (clk),
            .rst_n        (rst_n),
            .sd           (sdata[g]),
            .shift_i      (shift),
            .store_left_i (store_left),
            .commit_i     (commit),
            .pad_i        (pad),
            .valid_i      (valid_o),
            .left_o       (left_o[g*SAMPLE_W +: SAMPLE_W]),
            .right_o      (right_o[g*SAMPLE_W +: SAMPLE_W])
        );
    end

endmodule

// File: tb/serial_audio_rx_test.sv
// Self-checking bench for serial_audio_rx: directed and seeded random frames
// in every framing and word-length setting, compared with bench-computed
// expectations.
module serial_audio_rx_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lrck = 1'b0;
    logic [3:0]  sdata = '0;
    logic [1:0]  fmt = 2'b00;
    logic [1:0]  wlen = 2'b00;
    logic [95:0] left_o;
    logic [95:0] right_o;
    logic        valid_o;

    int tests = 0;
    int fails = 0;
    int sent = 0;
    int rcv = 0;
    bit done = 0;
    string tag = "R2";
    logic [23:0] exp_l [0:15][0:3];
    logic [23:0] exp_r [0:15][0:3];

    serial_audio_rx uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .lrck    (lrck),
        .sdata   (sdata),
        .fmt     (fmt),
        .wlen    (wlen),
        .left_o  (left_o),
        .right_o (right_o),
        .valid_o (valid_o)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [95:0] act, input logic [95:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    function automatic int wbits(input logic [1:0] c);
        return (c == 2'b00) ? 16 : (c == 2'b01) ? 20 : 24;
    endfunction

    // Bit for a given slot of a channel, junk outside the word (R8).
    function automatic logic slot_bit(input logic [1:0] f, input int wb, input logic [23:0] s, input int slot);
        if (f == 2'b01) begin
            if (slot < wb) return s[wb-1-slot];
        end else if (f == 2'b10) begin
            if (slot >= 32 - wb) return s[31-slot];
        end else begin
            if (slot >= 1 && slot <= wb) return s[wb-slot];
        end
        return logic'($urandom & 1);
    endfunction

    function automatic logic [23:0] align(input logic [23:0] s, input int wb);
        logic [23:0] m;
        m = (24'h1 << wb) - 24'h1;
        if (wb == 24) m = 24'hFFFFFF;
        return (s & m) << (24 - wb);
    endfunction

    // Monitor: each strobe is compared lane by lane (R6 R7).
    always @(negedge clk) begin
        if (rst_n && valid_o && !done) begin
            for (int n = 0; n < 4; n++) begin
                if (rcv < 16) begin
                    check(left_o[n*24 +: 24] == exp_l[rcv][n], {tag, " R6 left"},
                          96'(left_o[n*24 +: 24]), 96'(exp_l[rcv][n]));
                    check(right_o[n*24 +: 24] == exp_r[rcv][n], {tag, " R6 right"},
                          96'(right_o[n*24 +: 24]), 96'(exp_r[rcv][n]));
                end
            end
            rcv++;
        end
    end

    task automatic run_group(input logic [1:0] f, input logic [1:0] w, input int nfr);
        logic left_lvl;
        int wb;
        logic [23:0] sl [0:3];
        logic [23:0] sr [0:3];
        wb = wbits(w);
        left_lvl = (f == 2'b01 || f == 2'b10) ? 1'b1 : 1'b0;
        if (f == 2'b01) tag = "R3";
        else if (f == 2'b10) tag = "R4";
        else if (f == 2'b11) tag = "R10";
        else tag = "R2";
        if (w == 2'b11) tag = {tag, " R10"};
        else if (wb != 24) tag = {tag, " R5"};
        @(negedge clk);
        rst_n = 1'b0; fmt = f; wlen = w; lrck = ~left_lvl;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(valid_o == 1'b0 && left_o == '0 && right_o == '0, "R1 reset",
              left_o | right_o | 96'(valid_o), 96'h0);
        sent = 0; rcv = 0;
        rst_n = 1'b1;
        repeat (3) begin
            @(negedge clk); lrck = ~left_lvl; sdata = 4'($urandom);
        end
        for (int fr = 0; fr < nfr; fr++) begin
            for (int n = 0; n < 4; n++) begin
                if (fr == 0) begin sl[n] = 24'hFFFFFF; sr[n] = 24'h000000; end
                else if (fr == 1) begin sl[n] = (n % 2 == 0) ? 24'h800000 : 24'h000001; sr[n] = 24'h555555; end
                else begin sl[n] = 24'($urandom); sr[n] = 24'($urandom); end
                exp_l[fr][n] = align(sl[n], wb);
                exp_r[fr][n] = align(sr[n], wb);
            end
            sent++;
            for (int ch = 0; ch < 2; ch++) begin
                for (int s = 0; s < 32; s++) begin
                    @(negedge clk);
                    lrck = (ch == 0) ? left_lvl : ~left_lvl;
                    for (int n = 0; n < 4; n++)
                        sdata[n] = slot_bit(f == 2'b11 ? 2'b00 : f, wb,
                                            (ch == 0) ? sl[n] : sr[n], s);
                end
            end
        end
        repeat (4) @(negedge clk);
        // R7 R9 R11: one strobe per full frame, none before lock
        check(rcv == sent, "R7 R9 R11 strobe count", 96'(rcv), 96'(sent));
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd24680);
        for (int f = 0; f < 3; f++)
            for (int w = 0; w < 3; w++)
                run_group(2'(f), 2'(w), 8);
        run_group(2'b11, 2'b11, 6);
        run_group(2'b10, 2'b00, 6);
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule